// File: doc/BRIEF.md
# Reload-Counter Toggle PWM Timer

This block generates one pulse-width-modulated output line from an up-counting timer. The counter does not run from zero to a terminal count. It counts up to all-ones, overflows, and reloads a programmable load value. The output line toggles on the overflow and again when the counter leaves a programmable match value. The load value therefore sets the period, and the match value sets how long the line stays in its active state.

Software converts the times it wants into counter ticks. It writes a load value, a match value and a control word through a simple write port. A start command presets the counter two ticks short of overflow, so the first event is always an overflow that puts the line into its active state. An optional power-of-two prescaler slows the tick rate, and a polarity bit inverts the output sense.

All configuration is frozen while the timer runs. Software stops the timer, reprograms it and starts it again. A write that arrives while the timer is running is dropped and raises a sticky error flag. The only write accepted while running is the stop command.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the timer is stopped, `cntOut` is 0, `pwmOut` is 0 and `errFlag` is 0.
- R2: While the timer is stopped, a write to address 1 sets the load value and a write to address 2 sets the match value. A write to address 3 sets the counter, and the new value shows on `cntOut` after the clock edge that takes the write.
- R3: Address 0 is the control word. Bit 0 is run, bit 1 is invert, bit 2 is prescale enable, and bits 5:3 select the prescale. A control write with bit 0 = 1 while stopped starts the timer. It loads the other fields, presets the counter to all-ones minus one, and leaves the line in its inactive state.
- R4: While running, the counter rises by one on each tick. On a tick at all-ones it reloads the load value.
- R5: The line toggles on every overflow and on every tick that moves the counter off the match value. The line is active while the counter holds a value from load to match inclusive, which is match − load + 1 ticks. It is inactive for all-ones − match ticks, so the period is all-ones − load + 1 ticks.
- R6: The first overflow comes on the second tick after a start. Match events are suppressed until that first overflow, so a match value of all-ones minus one does not invert the phase.
- R7: With prescale enabled, one tick occurs every 2^(select+1) clocks, counted from the start. With prescale disabled, every clock is a tick.
- R8: `pwmOut` equals the internal active state XOR the invert bit. When the timer is stopped, `pwmOut` equals the invert bit.
- R9: A control write with bit 0 = 0 while running stops the timer at that clock edge. The counter then holds its value and `pwmOut` returns to the idle level. The other control bits in that write are ignored.
- R10: While running, a write to address 1, 2 or 3, or a control write with bit 0 = 1, changes nothing and sets `errFlag`. `errFlag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 load, 2 match, 3 counter |
| wrData | input | CNT_W | Write data |
| pwmOut | output | 1 | PWM output line |
| errFlag | output | 1 | Sticky flag: a write arrived while the timer was running |
| cntOut | output | CNT_W | Current counter value |

## Verification
A wrong reload or increment shows on `cntOut` at the very next tick, and a missed or extra toggle inverts `pwmOut` for the rest of the run. Comparing both outputs on every clock against a tick-count model therefore catches a fault within one period. A fault in the prescaler shifts every later tick and shows as a counter mismatch within one divided tick. A dropped guard on a write while running would change the waveform after the injected write, and the next sample would show it.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_LOAD  = 2'd1,
    ADDR_MATCH = 2'd2,
    ADDR_COUNT = 2'd3
  } regAddr_e;

  // control word bit positions
  localparam int CTRL_RUN      = 0;
  localparam int CTRL_INV      = 1;
  localparam int CTRL_PEN      = 2;
  localparam int CTRL_PSEL_LSB = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic ldCnt;
  } dpStrobe_t;

endpackage

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              running,
  output logic              errFlag,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  matchVal,
  output logic              invert,
  output logic              preEn,
  output logic [PRE_W-1:0]  preSel,
  output dpStrobe_t         stb
);

  regAddr_e addrDec;
  logic     isCtrl;
  logic     runBit;
  logic     cfgWr;
  logic     loadWr;
  logic     matchWr;
  logic     badWr;

  always_comb begin
    addrDec   = regAddr_e'(wrAddr);
    isCtrl    = wrEn && (addrDec == ADDR_CTRL);
    runBit    = wrData[CTRL_RUN];
    stb.start = isCtrl && runBit && !running;
    stb.stop  = isCtrl && !runBit && running;
    stb.ldCnt = wrEn && (addrDec == ADDR_COUNT) && !running;
    cfgWr     = isCtrl && !running;
    loadWr    = wrEn && (addrDec == ADDR_LOAD) && !running;
    matchWr   = wrEn && (addrDec == ADDR_MATCH) && !running;
    // while running, only a stop command is legal
    badWr     = wrEn && running && !(isCtrl && !runBit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      errFlag  <= 1'b0;
      loadVal  <= '0;
      matchVal <= '0;
      invert   <= 1'b0;
      preEn    <= 1'b0;
      preSel   <= '0;
    end else begin
      if (stb.start)     running <= 1'b1;
      else if (stb.stop) running <= 1'b0;
      if (badWr)   errFlag  <= 1'b1;
      if (loadWr)  loadVal  <= wrData;
      if (matchWr) matchVal <= wrData;
      if (cfgWr) begin
        invert <= wrData[CTRL_INV];
        preEn  <= wrData[CTRL_PEN];
        preSel <= wrData[CTRL_PSEL_LSB +: PRE_W];
      end
    end
  end

endmodule

// File: rtl/pwm_reload_dp.sv
module pwm_reload_dp
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] cntWrVal,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             preEn,
  input  logic [PRE_W-1:0] preSel,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             tick
);

  localparam int PDIV_W = 1 << PRE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [PDIV_W-1:0] preCnt;
  logic [PDIV_W-1:0] divMask;
  logic              primed;

  // mask of (select+1) low ones: divide by 2^(select+1)
  always_comb begin
    for (int i = 0; i < PDIV_W; i++) begin
      divMask[i] = (i <= int'(preSel));
    end
    tick = running && (!preEn || (preCnt == divMask));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
      active <= 1'b0;
      primed <= 1'b0;
    end else if (stb.start) begin
      cnt    <= CNT_PRE;
      preCnt <= '0;
      active <= 1'b0;
      primed <= 1'b0;
    end else if (stb.stop) begin
      preCnt <= '0;
      active <= 1'b0;
      primed <= 1'b0;
    end else if (stb.ldCnt) begin
      cnt <= cntWrVal;
    end else if (running) begin
      if (preEn) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
      end
      if (tick) begin
        if (cnt == CNT_MAX) begin
          cnt    <= loadVal;
          active <= ~active;
          primed <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (primed && (cnt == matchVal)) begin
            active <= ~active;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              errFlag,
  output logic [CNT_W-1:0]  cntOut
);

  dpStrobe_t        stb;
  logic             running;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] matchVal;
  logic             invert;
  logic             preEn;
  logic [PRE_W-1:0] preSel;
  logic             active;
  logic             tick;

  pwm_reload_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .running  (running),
    .errFlag  (errFlag),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .invert   (invert),
    .preEn    (preEn),
    .preSel   (preSel),
    .stb      (stb)
  );

  pwm_reload_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .running  (running),
    .stb      (stb),
    .cntWrVal (wrData),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .preEn    (preEn),
    .preSel   (preSel),
    .cnt      (cntOut),
    .active   (active),
    .tick     (tick)
  );

  assign pwmOut = active ^ invert;

endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              running,
  input logic              tick,
  input logic              startStb,
  input logic              stopStb,
  input logic              ldCntStb,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  cntOut,
  input logic [CNT_W-1:0]  loadVal,
  input logic              invert,
  input logic              pwmOut,
  input logic              errFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  start_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (cntOut == CNT_MAX - 1'b1) && (pwmOut == invert));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && tick && !stopStb && (cntOut != CNT_MAX) |=> cntOut == $past(cntOut) + 1'b1);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && tick && !stopStb && (cntOut == CNT_MAX) |=> cntOut == $past(loadVal));

  // R5
  overflow_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && tick && !stopStb && (cntOut == CNT_MAX) |=> pwmOut != $past(pwmOut));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> pwmOut == invert);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running && !startStb && !ldCntStb |=> $stable(cntOut));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R10
  load_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && wrEn && (wrAddr == ADDR_LOAD) |=> $stable(loadVal) && errFlag);

endmodule

bind pwm_reload_timer pwm_reload_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .running  (running),
  .tick     (tick),
  .startStb (stb.start),
  .stopStb  (stb.stop),
  .ldCntStb (stb.ldCnt),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .cntOut   (cntOut),
  .loadVal  (loadVal),
  .invert   (invert),
  .pwmOut   (pwmOut),
  .errFlag  (errFlag)
);

// File: tb/pwm_reload_timer_tb.sv
`timescale 1ns/1ps
module pwm_reload_timer_tb;

  localparam int CNT_W = 32;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic        pwmOut;
  logic        errFlag;
  logic [31:0] cntOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_reload_timer #(.CNT_W(CNT_W), .PRE_W(3)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .errFlag(errFlag), .cntOut(cntOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input bit run, input bit inv, input bit pen, input int sel);
    logic [31:0] w;
    w = '0;
    w[0] = run; w[1] = inv; w[2] = pen; w[5:3] = sel[2:0];
    return w;
  endfunction

  function automatic logic [31:0] expCnt(input logic [31:0] ld, input int n);
    longint period;
    if (n == 0) return MAXV - 1;
    if (n == 1) return MAXV;
    period = 64'hFFFF_FFFF - longint'(ld) + 1;
    return ld + 32'(longint'(n - 2) % period);
  endfunction

  function automatic bit expAct(input logic [31:0] ld, input logic [31:0] mt, input int n);
    longint period;
    longint pos;
    if (n < 2) return 1'b0;
    period = 64'hFFFF_FFFF - longint'(ld) + 1;
    pos = longint'(n - 2) % period;
    return pos <= longint'(mt - ld);
  endfunction

  // injKind: 0 none, 1 load write, 2 ctrl run write, 3 counter write
  task automatic runCheck(input logic [31:0] ld, input logic [31:0] mt, input bit inv,
                          input bit pen, input int sel, input int cycles,
                          input int injAt, input int injKind);
    int d;
    logic [31:0] held;
    d = pen ? (1 << (sel + 1)) : 1;
    regWrite(2'd1, ld);
    regWrite(2'd2, mt);
    regWrite(2'd0, ctrlWord(1'b1, inv, pen, sel));
    // R3: preset and inactive right after start
    chk("R3 start cnt", cntOut, MAXV - 1);
    chk("R3 start out", {31'd0, pwmOut}, {31'd0, inv});
    for (int k = 1; k <= cycles; k++) begin
      if (k == injAt && injKind != 0) begin
        wrEn = 1'b1;
        case (injKind)
          1: begin wrAddr = 2'd1; wrData = ld - 32'd7; end
          2: begin wrAddr = 2'd0; wrData = ctrlWord(1'b1, ~inv, ~pen, sel + 1); end
          default: begin wrAddr = 2'd3; wrData = 32'h1234_5678; end
        endcase
      end
      @(negedge clk);
      wrEn = 1'b0;
      // R4 R5 R6 R7 R8: waveform and counter against tick model
      chk("R4/R7 cnt", cntOut, expCnt(ld, k / d));
      chk("R5/R6/R8 out", {31'd0, pwmOut}, {31'd0, expAct(ld, mt, k / d) ^ inv});
      if (k == injAt && injKind != 0) chk("R10 err set", {31'd0, errFlag}, 32'd1);
    end
    // R9: stop with other bits flipped; they must be ignored
    held = cntOut;
    regWrite(2'd0, ctrlWord(1'b0, ~inv, ~pen, sel + 2));
    chk("R9 stop out", {31'd0, pwmOut}, {31'd0, inv});
    repeat (4) @(negedge clk);
    chk("R9 frozen cnt", cntOut, held);
    chk("R9 idle out", {31'd0, pwmOut}, {31'd0, inv});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ld;
    logic [31:0] mt;
    void'($urandom(32'd4711));
    doReset();
    // R1
    chk("R1 cnt", cntOut, 32'd0);
    chk("R1 out", {31'd0, pwmOut}, 32'd0);
    chk("R1 err", {31'd0, errFlag}, 32'd0);

    // R2: counter write while stopped
    regWrite(2'd3, 32'hCAFE_0042);
    chk("R2 cnt write", cntOut, 32'hCAFE_0042);
    // R8: idle polarity follows invert bit
    regWrite(2'd0, ctrlWord(1'b0, 1'b1, 1'b0, 0));
    chk("R8 idle inverted", {31'd0, pwmOut}, 32'd1);
    chk("R2 ctrl keeps cnt", cntOut, 32'hCAFE_0042);
    regWrite(2'd0, ctrlWord(1'b0, 1'b0, 1'b0, 0));
    chk("R8 idle normal", {31'd0, pwmOut}, 32'd0);

    // directed: plain waveform
    runCheck(MAXV - 9, MAXV - 5, 1'b0, 1'b0, 0, 40, 0, 0);
    // R6 corner: match at all-ones minus one
    runCheck(MAXV - 6, MAXV - 1, 1'b0, 1'b0, 0, 30, 0, 0);
    // R5 corner: one-tick active (load equals match), inverted
    runCheck(MAXV - 4, MAXV - 4, 1'b1, 1'b0, 0, 25, 0, 0);
    // R7: prescale select 2 (divide by 8)
    runCheck(MAXV - 3, MAXV - 2, 1'b0, 1'b1, 2, 90, 0, 0);

    // R10: each illegal write while running, reset between to clear sticky flag
    for (int kind = 1; kind <= 3; kind++) begin
      doReset();
      chk("R1 err clear", {31'd0, errFlag}, 32'd0);
      runCheck(MAXV - 7, MAXV - 3, kind[0], 1'b0, 0, 30, 11, kind);
      chk("R10 err sticky", {31'd0, errFlag}, 32'd1);
    end
    doReset();

    // random configurations
    for (int t = 0; t < 8; t++) begin
      int span;
      int sel;
      bit pen;
      bit inv;
      int d;
      span = 4 + int'($urandom % 40);
      ld   = MAXV - 32'(span);
      mt   = ld + ($urandom % 32'(span));
      sel  = int'($urandom % 3);
      pen  = 1'($urandom);
      inv  = 1'($urandom);
      d    = pen ? (1 << (sel + 1)) : 1;
      runCheck(ld, mt, inv, pen, sel, 2 * (span + 1) * d + 8, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule